// File: doc/BRIEF.md
# Chained Inter-Processor Mailbox

This block lets two processor channels pass short messages through a small bank of mailboxes. Each mailbox holds an owner, a destination, a per-channel interrupt mask, a mode, a two-bit send/acknowledge field and a 32-bit payload. A sending channel claims a free mailbox by writing its own one-hot identifier into the owner field. It then programs the destination, mask, payload and mode, and sets the "sent" bit. The destination channel takes the interrupt, reads the payload and replies with a manual acknowledge: in a single write it clears the "sent" bit and sets the "acknowledged" bit.

Mailboxes can be chained. When a mailbox's link mode bit is set, the rising edge of its acknowledge bit raises the "sent" bit of the next-numbered mailbox on its own, with no software write. An acknowledge on a linked mailbox does not signal the owner. Only the acknowledge on the last mailbox of the chain raises the sender's interrupt. The sender ends the exchange by clearing the acknowledge bits. All access goes through a single-cycle register port that carries the requesting channel's one-hot identifier. Reads are combinational.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset all mailbox fields read zero, every status read returns zero and both interrupt outputs are low.
- R2: The address is {mailbox index, register index}. Register index 0 is owner, 1 destination, 2 mask, 3 mode, 4 send/ack, 5 payload and 6 the raw status of the requesting channel (bit m = mailbox m). Index 7 reads zero, and writes to 6 and 7 are ignored.
- R3: Channel identifiers are one-hot: bit 0 for the first channel, bit 1 for the second. A write to the owner register of a free mailbox (owner zero) takes effect only when the data equals the writer's identifier. Any other owner write to a free mailbox is ignored.
- R4: The owning channel writing zero to the owner register releases the mailbox and clears owner, destination, mask, mode and send/ack. The payload is kept. Nonzero owner writes to a claimed mailbox are ignored.
- R5: Destination, mask, mode and payload writes are accepted only from the owning channel. Writes from any other channel, or to a free mailbox, leave the register unchanged.
- R6: Send/ack writes (bit 0 = sent, bit 1 = acknowledged) are accepted from the owner, or from a channel whose bit is set in the destination. Other send/ack writes and writes to a free mailbox are ignored.
- R7: While the sent bit is set, the raw status bit of that mailbox is high for every channel whose bit is set in the destination.
- R8: While the acknowledged bit of an unlinked mailbox is set, its raw status bit is high for the owner channel.
- R9: When mode bit 1 (link) is set on mailbox m below the last, a 0-to-1 change of m's acknowledged bit sets mailbox m+1's send/ack to 01 on the same clock edge. The acknowledge of a linked mailbox gives no owner status.
- R10: The link bit of the last mailbox has no effect: its acknowledge signals its owner.
- R11: Interrupt output c is high exactly when some mailbox has raw status for channel c and its mask bit c set.
- R12: The owner clearing the acknowledged bit removes that mailbox's status and drops the interrupt it caused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_id | input | NCH | One-hot identifier of the requesting channel |
| bus_addr | input | log2(NMB)+3 | {mailbox index, register index} |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr and bus_id |
| irq | output | NCH | Interrupt per channel |

## Verification
A directed two-mailbox chain runs from claim to final clear. It shows whether the acknowledge of the linked first mailbox forwards the send and withholds the sender's interrupt, and whether the final acknowledge alone raises it. A separate link on the last mailbox shows that the chain end is honoured rather than forwarding past the bank. Random writes use random channels, addresses and small data values, so most owner, send and configuration writes come from a channel without the right to make them. These writes separate the ownership and destination gating from the field storage, and each one is compared against a bench model on interrupts and read-back.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NMB = 4,
  parameter int NCH = 2,
  parameter int DW  = 32,
  localparam int MBW = $clog2(NMB),
  localparam int AW  = MBW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [NCH-1:0] bus_id,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);

  localparam logic [2:0] R_OWN = 3'd0, R_DST = 3'd1, R_MSK = 3'd2,
                         R_MOD = 3'd3, R_SND = 3'd4, R_DAT = 3'd5, R_RAW = 3'd6;

  logic [NCH-1:0] own_q [NMB];
  logic [NCH-1:0] dst_q [NMB];
  logic [NCH-1:0] msk_q [NMB];
  logic [1:0]     mode_q[NMB];
  logic [1:0]     snd_q [NMB];
  logic [DW-1:0]  dat_q [NMB];

  logic [MBW-1:0] mb;
  logic [2:0]     rg;
  assign mb = bus_addr[AW-1:3];
  assign rg = bus_addr[2:0];

  logic [NMB:0]   fwd;
  logic [NMB-1:0] link;
  logic [NCH-1:0][NMB-1:0] raw;
  logic [NCH-1:0][NMB-1:0] pend;

  assign fwd[0] = 1'b0;

  for (genvar m = 0; m < NMB; m++) begin : g_mb
    logic hit, free, is_own, claim, rel, cfg_ok, snd_ok;
    logic [1:0] snd_nxt;

    assign hit     = bus_wr && (mb == MBW'(m));
    assign free    = (own_q[m] == '0);
    assign is_own  = !free && (own_q[m] == bus_id);
    assign claim   = hit && rg == R_OWN && free && (|bus_id) &&
                     (bus_wdata == DW'(bus_id));
    assign rel     = hit && rg == R_OWN && is_own && (bus_wdata == '0);
    assign cfg_ok  = hit && is_own;
    assign snd_ok  = hit && rg == R_SND && !free &&
                     (is_own || (|(dst_q[m] & bus_id)));
    assign snd_nxt = snd_ok ? bus_wdata[1:0] : snd_q[m];
    assign link[m] = mode_q[m][1] && (m != NMB - 1);
    assign fwd[m+1] = link[m] && !snd_q[m][1] && snd_nxt[1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_q[m]  <= '0;
        dst_q[m]  <= '0;
        msk_q[m]  <= '0;
        mode_q[m] <= '0;
        snd_q[m]  <= '0;
        dat_q[m]  <= '0;
      end else if (rel) begin
        own_q[m]  <= '0;
        dst_q[m]  <= '0;
        msk_q[m]  <= '0;
        mode_q[m] <= '0;
        snd_q[m]  <= '0;
      end else begin
        if (claim) own_q[m] <= bus_id;
        if (cfg_ok && rg == R_DST) dst_q[m]  <= bus_wdata[NCH-1:0];
        if (cfg_ok && rg == R_MSK) msk_q[m]  <= bus_wdata[NCH-1:0];
        if (cfg_ok && rg == R_MOD) mode_q[m] <= bus_wdata[1:0];
        if (cfg_ok && rg == R_DAT) dat_q[m]  <= bus_wdata;
        snd_q[m] <= fwd[m] ? 2'b01 : snd_nxt;
      end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign raw[c][m]  = (snd_q[m][0] && dst_q[m][c]) ||
                          (snd_q[m][1] && own_q[m][c] && !link[m]);
      assign pend[c][m] = raw[c][m] && msk_q[m][c];
    end

    // R3
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_q[m]));

    // R4
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mb == MBW'(m) && rg == R_OWN && own_q[m] != '0 &&
       own_q[m] == bus_id && bus_wdata == '0)
      |=> (own_q[m] == '0 && dst_q[m] == '0 && msk_q[m] == '0 &&
           mode_q[m] == '0 && snd_q[m] == '0 && $stable(dat_q[m])));

    // R5
    foreign_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mb == MBW'(m) && rg == R_DAT &&
       (own_q[m] == '0 || own_q[m] != bus_id))
      |=> $stable(dat_q[m]));

    if (m < NMB - 1) begin : g_fwd_chk
      // R9
      chain_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[m][1] && $rose(snd_q[m][1])) |-> (snd_q[m+1] == 2'b01));
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    assign irq[c] = |pend[c];
  end

  logic [NMB-1:0] raw_sel;
  always_comb begin
    raw_sel = '0;
    for (int c = 0; c < NCH; c++)
      if (bus_id[c]) raw_sel = raw_sel | raw[c];
  end

  always_comb begin
    case (rg)
      R_OWN:   bus_rdata = DW'(own_q[mb]);
      R_DST:   bus_rdata = DW'(dst_q[mb]);
      R_MSK:   bus_rdata = DW'(msk_q[mb]);
      R_MOD:   bus_rdata = DW'(mode_q[mb]);
      R_SND:   bus_rdata = DW'(snd_q[mb]);
      R_DAT:   bus_rdata = dat_q[mb];
      R_RAW:   bus_rdata = DW'(raw_sel);
      default: bus_rdata = '0;
    endcase
  end

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (raw[0] != '0));

endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_id = 2'b01;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [1:0]  e_own[4], e_dst[4], e_msk[4], e_mod[4], e_snd[4];
  logic [31:0] e_dat[4];

  ipc_mailbox uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_id(bus_id),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  function automatic bit e_link(int m);
    return e_mod[m][1] && m != 3;
  endfunction

  function automatic bit e_raw(int c, int m);
    return (e_snd[m][0] && e_dst[m][c]) || (e_snd[m][1] && e_own[m][c] && !e_link(m));
  endfunction

  function automatic logic [1:0] e_irq();
    logic [1:0] r = '0;
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 4; m++) if (e_raw(c, m) && e_msk[m][c]) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] e_read(logic [1:0] id, int m, int r);
    logic [31:0] v = '0;
    case (r)
      0: v = 32'(e_own[m]);
      1: v = 32'(e_dst[m]);
      2: v = 32'(e_msk[m]);
      3: v = 32'(e_mod[m]);
      4: v = 32'(e_snd[m]);
      5: v = e_dat[m];
      6: for (int k = 0; k < 4; k++)
           v[k] = (id[0] && e_raw(0, k)) || (id[1] && e_raw(1, k));
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_write(logic [1:0] id, int m, int r, logic [31:0] d);
    bit free = (e_own[m] == 0);
    bit own = !free && e_own[m] == id;
    logic [1:0] nx = e_snd[m];
    if (r == 0 && own && d == 0) begin
      e_own[m] = 0; e_dst[m] = 0; e_msk[m] = 0; e_mod[m] = 0; e_snd[m] = 0;
      return;
    end
    if (r == 0 && free && id != 0 && d == 32'(id)) e_own[m] = id;
    if (own && r == 1) e_dst[m] = d[1:0];
    if (own && r == 2) e_msk[m] = d[1:0];
    if (own && r == 3) e_mod[m] = d[1:0];
    if (own && r == 5) e_dat[m] = d;
    if (r == 4 && !free && (own || (e_dst[m] & id) != 0)) nx = d[1:0];
    if (e_link(m) && !e_snd[m][1] && nx[1]) e_snd[m+1] = 2'b01;
    e_snd[m] = nx;
  endtask

  task automatic wr(logic [1:0] id, int m, int r, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_id = id; bus_addr = {m[1:0], r[2:0]}; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 0;
    model_write(id, m, r, d);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] id, int m, int r, output logic [31:0] v);
    bus_id = id; bus_addr = {m[1:0], r[2:0]};
    #1 v = bus_rdata;
  endtask

  task automatic cmp_read(string req, logic [1:0] id, int m, int r);
    logic [31:0] v;
    rd(id, m, r, v);
    chk(req, v, e_read(id, m, r));
  endtask

  task automatic cmp_all(string req);
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 8; r++) cmp_read(req, 2'b01, m, r);
    cmp_read(req, 2'b10, 0, 6);
    chk({req, " irq R11"}, 32'(irq), 32'(e_irq()));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int m = 0; m < 4; m++) begin
      e_own[m] = 0; e_dst[m] = 0; e_msk[m] = 0; e_mod[m] = 0; e_snd[m] = 0; e_dat[m] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    cmp_all("R1 reset");
    chk("R1 irq low", 32'(irq), 32'd0);

    // directed chain: channel 1 sends two linked messages to channel 2
    wr(2'b01, 0, 0, 32'h1);
    wr(2'b01, 1, 0, 32'h1);
    rd(2'b10, 0, 0, v); chk("R3 claim", v, 32'h1);
    wr(2'b10, 0, 0, 32'h2);
    rd(2'b10, 0, 0, v); chk("R3 foreign claim ignored", v, 32'h1);
    wr(2'b01, 0, 3, 32'h2);
    wr(2'b01, 0, 2, 32'h3);
    wr(2'b01, 0, 1, 32'h2);
    wr(2'b01, 0, 5, 32'hDA7A0000);
    wr(2'b01, 1, 2, 32'h3);
    wr(2'b01, 1, 1, 32'h2);
    wr(2'b01, 1, 5, 32'hDA7A1111);
    wr(2'b10, 1, 5, 32'h0BAD0BAD);
    rd(2'b10, 1, 5, v); chk("R5 foreign payload ignored", v, 32'hDA7A1111);
    wr(2'b01, 0, 4, 32'h1);
    chk("R7 dest irq", 32'(irq), 32'h2);
    rd(2'b10, 0, 6, v); chk("R7 dest raw", v, 32'h1);
    wr(2'b10, 0, 4, 32'h2);
    rd(2'b10, 1, 4, v); chk("R9 forwarded send", v, 32'h1);
    rd(2'b01, 0, 6, v); chk("R9 linked ack no owner status", v, 32'h0);
    chk("R9 no sender irq", 32'(irq[0]), 32'h0);
    rd(2'b10, 0, 6, v); chk("R9 dest raw moves", v, 32'h2);
    wr(2'b10, 1, 4, 32'h2);
    rd(2'b01, 0, 6, v); chk("R8 final ack status", v, 32'h2);
    chk("R11 sender irq", 32'(irq), 32'h1);
    wr(2'b01, 0, 4, 32'h0);
    wr(2'b01, 1, 4, 32'h0);
    chk("R12 ack clear drops irq", 32'(irq), 32'h0);
    cmp_all("R9 chain end");

    // last mailbox link ignored
    wr(2'b10, 3, 0, 32'h2);
    wr(2'b10, 3, 3, 32'h2);
    wr(2'b10, 3, 2, 32'h2);
    wr(2'b10, 3, 1, 32'h1);
    wr(2'b10, 3, 4, 32'h1);
    chk("R7 no mask no irq", 32'(irq), 32'h0);
    wr(2'b01, 3, 4, 32'h2);
    rd(2'b10, 3, 6, v); chk("R10 last link ignored", v, 32'h8);
    chk("R11 masked irq", 32'(irq), 32'h2);
    wr(2'b01, 3, 0, 32'h0);
    rd(2'b01, 3, 0, v); chk("R4 non-owner release ignored", v, 32'h2);
    wr(2'b10, 3, 0, 32'h0);
    cmp_all("R4 release");
    chk("R4 irq after release", 32'(irq), 32'h0);
    wr(2'b10, 3, 4, 32'h1);
    rd(2'b10, 3, 4, v); chk("R6 send on free ignored", v, 32'h0);
    wr(2'b01, 2, 6, 32'hF);
    cmp_read("R2 status write ignored", 2'b01, 2, 6);
    cmp_read("R2 index 7 reads zero", 2'b01, 2, 7);

    for (int i = 0; i < 1500; i++) begin
      logic [1:0] id = ($urandom % 2) ? 2'b10 : 2'b01;
      int m = $urandom % 4;
      int r = $urandom % 8;
      logic [31:0] d = (r == 5) ? $urandom : ($urandom % 4);
      if (r == 0 && ($urandom % 3) != 0) d = ($urandom % 2) ? 32'(id) : 0;
      if (r == 7) r = 4;
      wr(id, m, r, d);
      chk("R11 random irq", 32'(irq), 32'(e_irq()));
      for (int k = 0; k < 3; k++) begin
        logic [1:0] rid = ($urandom % 2) ? 2'b10 : 2'b01;
        cmp_read("R5 R6 R8 random read", rid, $urandom % 4, $urandom % 8);
      end
      if (i % 300 == 299) cmp_all("R9 random sweep");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule